// File: doc/BRIEF.md
# Quad Potentiometer Command Decoder

This block sits behind a two-wire serial bus front end and turns the bytes it receives into operations on four digital potentiometers. Each potentiometer has one 6-bit wiper counter register (WCR) that sets the tap position, and four 6-bit data registers that model nonvolatile storage. The front end reports bus start and stop conditions, delivers each received byte with a one-cycle strobe, and drives the acknowledge bit from the decoder's `ackEn` pulse. For reads it sends `txByte`. During an increment/decrement command it passes each step clock with its direction.

A transaction opens with an address byte. The upper nibble is a fixed device code and the lower nibble matches the `devAddr` pins. The instruction byte follows. Its bits 7..4 carry the opcode, bits 3..2 pick the potentiometer and bits 1..0 pick the data register. Transfers between a data register and a WCR complete with the instruction byte. They act on one potentiometer, or in their global forms on all four at once using the same register index. Host reads and writes of a WCR or a data register use a third byte. Every write into a data register starts a busy window of `NV_CYCLES` clocks. While it runs the device ignores its own address. The wiper outputs follow the WCRs one clock later.

Top module: `qpot_decoder`

## Requirements
- R1: After a start, the first received byte is acknowledged (one-cycle `ackEn` pulse in the cycle after `rxValid`) only if it equals {DEV_ID = 4'b0101, devAddr} and no busy window is running. Any other address is not acknowledged, and all bytes up to the next start are then ignored.
- R2: The defined opcodes are 9 = read WCR, A = write WCR, B = read data register, C = write data register, D = data register to WCR, E = WCR to data register, 1 = global data register to WCR, 8 = global WCR to data register, and 2 = increment/decrement. Any other opcode is not acknowledged and changes no register.
- R3: Write WCR (opcode A): the acknowledged third byte's bits 5..0 load the selected WCR. The matching 6-bit field of `wiperBus` (pot n at bits 6n+5..6n) shows the new value one clock after the WCR changes.
- R4: Write data register (opcode C): the acknowledged third byte's bits 5..0 are stored in the selected data register of the selected pot, and a busy window starts.
- R5: Read WCR (opcode 9) and read data register (opcode B): once the instruction byte is acknowledged, `txByte` holds {2'b00, value} and `txValid` is high until the next stop or start.
- R6: Opcode D copies the selected data register of the selected pot into that pot's WCR.
- R7: Opcode E copies the selected pot's WCR into its selected data register and starts a busy window.
- R8: Global opcodes 1 and 8 perform the transfer of R6 or R7 on all four pots at the register index in bits 1..0. The pot field is ignored.
- R9: A busy window lasts exactly NV_CYCLES clocks after the byte that started it is taken. An address byte that arrives while clocks remain in the window is not acknowledged. One that arrives after the window has ended is acknowledged.
- R10: A stop that arrives before the data byte of a write instruction aborts the instruction, and no register changes.
- R11: After opcode 2 is acknowledged, each `stepValid` pulse moves the selected WCR by one, up if `stepUp` is high and down otherwise. The WCR saturates at 63 and at 0.
- R12: After a two-byte instruction, a read instruction or a completed write, further bytes are not acknowledged until the next start.
- R13: After reset all WCRs, data registers, `wiperBus`, `txByte`, `ackEn` and `txValid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devAddr | input | 4 | Device address pins compared with the address byte's low nibble |
| startSeen | input | 1 | One-cycle pulse: bus start condition |
| stopSeen | input | 1 | One-cycle pulse: bus stop condition |
| rxValid | input | 1 | One-cycle pulse: `rxByte` holds a received byte |
| rxByte | input | 8 | Received byte |
| stepValid | input | 1 | One-cycle pulse: one increment/decrement step |
| stepUp | input | 1 | Step direction, 1 = towards the top of the range |
| ackEn | output | 1 | One-cycle pulse: acknowledge the last byte |
| txValid | output | 1 | Read data is available in `txByte` |
| txByte | output | 8 | Byte for the front end to send on a read |
| wiperBus | output | 24 | Four 6-bit wiper positions, pot 0 in the low bits |

## Verification
Two functions can meet in the same clock: the busy window running out and a new address byte being judged. The bench times a stop, a start and a counted run of idle clocks after a data register write. This places the address byte exactly one clock before the window ends, and then in the clock where it has just ended. It expects a refusal in the first case and an acknowledge in the second. A second case is a stop that arrives between a write instruction and its data byte. The bench checks afterwards that the register model and the wiper outputs are unchanged.

// File: rtl/qpot_pkg.sv
package qpot_pkg;
  localparam int POT_W  = 6;
  localparam int NPOT   = 4;
  localparam int NREG   = 4;
  localparam int IDX_W  = $clog2(NPOT);
  localparam int RIDX_W = $clog2(NREG);
  localparam int BYTE_W = 8;

  localparam logic [3:0] OP_RD_WCR  = 4'h9;
  localparam logic [3:0] OP_WR_WCR  = 4'hA;
  localparam logic [3:0] OP_RD_DR   = 4'hB;
  localparam logic [3:0] OP_WR_DR   = 4'hC;
  localparam logic [3:0] OP_LD_WCR  = 4'hD;
  localparam logic [3:0] OP_ST_DR   = 4'hE;
  localparam logic [3:0] OP_GLD_WCR = 4'h1;
  localparam logic [3:0] OP_GST_DR  = 4'h8;
  localparam logic [3:0] OP_STEP    = 4'h2;

  typedef struct packed {
    logic              wrWcr;
    logic              wrDr;
    logic              toWcr;
    logic              toDr;
    logic              global;
    logic              step;
    logic              stepUp;
    logic              loadTx;
    logic              txFromDr;
    logic [IDX_W-1:0]  pot;
    logic [RIDX_W-1:0] regSel;
    logic [POT_W-1:0]  data;
  } ctlStrobe_t;
endpackage

// File: rtl/qpot_ctrl.sv
module qpot_ctrl
  import qpot_pkg::*;
#(
  parameter int         NV_CYCLES = 200,
  parameter logic [3:0] DEV_ID    = 4'b0101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        devAddr,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              stepValid,
  input  logic              stepUp,
  output logic              ackEn,
  output logic              txValid,
  output ctlStrobe_t        strobe
);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NV_CYCLES);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_STEP, ST_DONE} state_t;

  state_t            state;
  logic [3:0]        opReg;
  logic [IDX_W-1:0]  potReg;
  logic [RIDX_W-1:0] regReg;
  logic [CNT_W-1:0]  busyCnt;

  logic       byteIn;
  logic       addrHit;
  logic       opKnown;
  logic       busy;
  logic       nvStart;
  logic [3:0] opc;

  assign byteIn  = rxValid && !startSeen && !stopSeen;
  assign opc     = rxByte[7:4];
  assign addrHit = (rxByte == {DEV_ID, devAddr});
  assign busy    = (busyCnt != '0);

  always_comb begin
    unique case (opc)
      OP_RD_WCR, OP_WR_WCR, OP_RD_DR, OP_WR_DR, OP_LD_WCR,
      OP_ST_DR, OP_GLD_WCR, OP_GST_DR, OP_STEP: opKnown = 1'b1;
      default: opKnown = 1'b0;
    endcase
  end

  // Strobes to the datapath
  always_comb begin
    strobe        = '0;
    strobe.stepUp = stepUp;
    strobe.data   = rxByte[POT_W-1:0];
    strobe.pot    = (state == ST_INSTR) ? rxByte[3:2] : potReg;
    strobe.regSel = (state == ST_INSTR) ? rxByte[1:0] : regReg;
    if (byteIn && state == ST_INSTR) begin
      unique case (opc)
        OP_LD_WCR:  strobe.toWcr = 1'b1;
        OP_ST_DR:   strobe.toDr  = 1'b1;
        OP_GLD_WCR: begin strobe.toWcr = 1'b1; strobe.global = 1'b1; end
        OP_GST_DR:  begin strobe.toDr  = 1'b1; strobe.global = 1'b1; end
        OP_RD_WCR:  strobe.loadTx = 1'b1;
        OP_RD_DR:   begin strobe.loadTx = 1'b1; strobe.txFromDr = 1'b1; end
        default: ;
      endcase
    end
    if (byteIn && state == ST_DATA) begin
      strobe.wrWcr = (opReg == OP_WR_WCR);
      strobe.wrDr  = (opReg == OP_WR_DR);
    end
    if (state == ST_STEP && stepValid && !startSeen && !stopSeen)
      strobe.step = 1'b1;
  end

  assign nvStart = strobe.toDr || strobe.wrDr;

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (nvStart) busyCnt <= CNT_LOAD;
    else if (busy) busyCnt <= busyCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ackEn   <= 1'b0;
      txValid <= 1'b0;
      opReg   <= '0;
      potReg  <= '0;
      regReg  <= '0;
    end else begin
      ackEn <= 1'b0;
      if (startSeen) begin
        state   <= ST_ADDR;
        txValid <= 1'b0;
      end else if (stopSeen) begin
        state   <= ST_IDLE;
        txValid <= 1'b0;
      end else if (rxValid) begin
        unique case (state)
          ST_ADDR: begin
            if (addrHit && !busy) begin
              ackEn <= 1'b1;
              state <= ST_INSTR;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_INSTR: begin
            if (opKnown) begin
              ackEn  <= 1'b1;
              opReg  <= opc;
              potReg <= rxByte[3:2];
              regReg <= rxByte[1:0];
              if (opc == OP_WR_WCR || opc == OP_WR_DR) state <= ST_DATA;
              else if (opc == OP_STEP) state <= ST_STEP;
              else begin
                state <= ST_DONE;
                if (opc == OP_RD_WCR || opc == OP_RD_DR) txValid <= 1'b1;
              end
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_DATA: begin
            ackEn <= 1'b1;
            state <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assert_ack_after_byte_R12: assert property (@(posedge clk) disable iff (!rstN)
    ackEn |-> $past(rxValid));
  assert_busy_addr_nack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (byteIn && state == ST_ADDR && busyCnt != '0) |=> !ackEn);
  assert_abort_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !(strobe.wrWcr || strobe.wrDr));
  assert_tx_after_instr_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> ($past(rxValid) && $past(state) == ST_INSTR));
endmodule

// File: rtl/qpot_dp.sv
module qpot_dp
  import qpot_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              strobe,
  output logic [BYTE_W-1:0]       txByte,
  output logic [NPOT*POT_W-1:0]   wiperBus
);
  localparam logic [POT_W-1:0] MAXV = {POT_W{1'b1}};

  logic [POT_W-1:0] wcrAll [NPOT];
  logic [POT_W-1:0] drAll  [NPOT][NREG];

  for (genvar p = 0; p < NPOT; p++) begin : gPot
    logic [POT_W-1:0] wcrQ;
    logic [POT_W-1:0] wipQ;
    logic             hit;
    logic             xHit;

    assign hit  = (strobe.pot == IDX_W'(p));
    assign xHit = strobe.global || hit;

    always_ff @(posedge clk) begin
      if (!rstN) wcrQ <= '0;
      else if (strobe.wrWcr && hit) wcrQ <= strobe.data;
      else if (strobe.toWcr && xHit) wcrQ <= drAll[p][strobe.regSel];
      else if (strobe.step && hit) begin
        if (strobe.stepUp && wcrQ != MAXV) wcrQ <= wcrQ + 1'b1;
        else if (!strobe.stepUp && wcrQ != '0) wcrQ <= wcrQ - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) wipQ <= '0;
      else wipQ <= wcrQ;
    end

    assign wcrAll[p] = wcrQ;
    assign wiperBus[p*POT_W +: POT_W] = wipQ;

    for (genvar r = 0; r < NREG; r++) begin : gReg
      logic [POT_W-1:0] drQ;
      logic             rHit;
      assign rHit = (strobe.regSel == RIDX_W'(r));
      always_ff @(posedge clk) begin
        if (!rstN) drQ <= '0;
        else if (strobe.wrDr && hit && rHit) drQ <= strobe.data;
        else if (strobe.toDr && xHit && rHit) drQ <= wcrQ;
      end
      assign drAll[p][r] = drQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txByte <= '0;
    else if (strobe.loadTx)
      txByte <= {{(BYTE_W-POT_W){1'b0}},
                 strobe.txFromDr ? drAll[strobe.pot][strobe.regSel] : wcrAll[strobe.pot]};
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrWcr, strobe.wrDr, strobe.toWcr, strobe.toDr, strobe.step, strobe.loadTx}));
  assert_step_floor_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.stepUp && wcrAll[strobe.pot] == '0) |=> wcrAll[$past(strobe.pot)] == '0);
  assert_step_ceiling_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && strobe.stepUp && wcrAll[strobe.pot] == MAXV) |=> wcrAll[$past(strobe.pot)] == MAXV);
endmodule

// File: rtl/qpot_decoder.sv
module qpot_decoder
  import qpot_pkg::*;
#(
  parameter int         NV_CYCLES = 200,
  parameter logic [3:0] DEV_ID    = 4'b0101
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  devAddr,
  input  logic        startSeen,
  input  logic        stopSeen,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        stepValid,
  input  logic        stepUp,
  output logic        ackEn,
  output logic        txValid,
  output logic [7:0]  txByte,
  output logic [23:0] wiperBus
);
  ctlStrobe_t strobe;

  qpot_ctrl #(.NV_CYCLES(NV_CYCLES), .DEV_ID(DEV_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .startSeen(startSeen),
    .stopSeen(stopSeen), .rxValid(rxValid), .rxByte(rxByte),
    .stepValid(stepValid), .stepUp(stepUp), .ackEn(ackEn),
    .txValid(txValid), .strobe(strobe)
  );

  qpot_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(txByte), .wiperBus(wiperBus)
  );
endmodule

// File: tb/tb_qpot_decoder.sv
module tb_qpot_decoder;
  localparam int NV = 200;
  localparam logic [3:0] DEVA = 4'h6;
  localparam logic [7:0] ADDR = {4'b0101, DEVA};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] devAddr = DEVA;
  logic startSeen = 0, stopSeen = 0, rxValid = 0, stepValid = 0, stepUp = 0;
  logic [7:0] rxByte = '0;
  logic ackEn, txValid;
  logic [7:0] txByte;
  logic [23:0] wiperBus;

  int nChecks = 0;
  int nFails  = 0;
  logic [5:0] mW [4];
  logic [5:0] mD [4][4];

  always #5 clk = ~clk;

  qpot_decoder #(.NV_CYCLES(NV)) dut (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .startSeen(startSeen),
    .stopSeen(stopSeen), .rxValid(rxValid), .rxByte(rxByte),
    .stepValid(stepValid), .stepUp(stepUp), .ackEn(ackEn),
    .txValid(txValid), .txByte(txByte), .wiperBus(wiperBus)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit isKnown(logic [3:0] op);
    return op inside {4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'h1, 4'h8, 4'h2};
  endfunction

  function automatic bit isNv(logic [3:0] op);
    return op inside {4'hC, 4'hE, 4'h8};
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doStart();
    startSeen = 1; @(negedge clk); startSeen = 0;
  endtask

  task automatic doStop();
    stopSeen = 1; @(negedge clk); stopSeen = 0;
  endtask

  task automatic sendByte(logic [7:0] b, output logic ack);
    rxByte = b; rxValid = 1; @(negedge clk); rxValid = 0; ack = ackEn;
  endtask

  task automatic doStep(logic up);
    stepUp = up; stepValid = 1; @(negedge clk); stepValid = 0;
    if (up && mW[0] != 6'h3F) begin end
  endtask

  task automatic checkWipers(string req);
    for (int p = 0; p < 4; p++) check(req, wiperBus[p*6 +: 6], mW[p]);
  endtask

  // Full transaction with model update; returns after the stop.
  task automatic runOp(logic [3:0] op, logic [1:0] pot, logic [1:0] rg, logic [5:0] dat,
                       int steps, bit abort);
    logic ack;
    logic [5:0] v;
    doStart();
    sendByte(ADDR, ack); check("R1 address ack", ack, 1);
    sendByte({op, pot, rg}, ack); check("R2 opcode ack", ack, isKnown(op));
    if (isKnown(op)) begin
      case (op)
        4'hA, 4'hC: begin
          if (!abort) begin
            sendByte({2'b11, dat}, ack); check("R3 R4 data ack", ack, 1);
            if (op == 4'hA) mW[pot] = dat; else mD[pot][rg] = dat;
            sendByte(8'h5A, ack); check("R12 extra byte nack", ack, 0);
          end
        end
        4'h9, 4'hB: begin
          v = (op == 4'h9) ? mW[pot] : mD[pot][rg];
          check("R5 txValid", txValid, 1);
          check("R5 txByte", txByte, {2'b00, v});
        end
        4'hD: mW[pot] = mD[pot][rg];
        4'hE: mD[pot][rg] = mW[pot];
        4'h1: for (int p = 0; p < 4; p++) mW[p] = mD[p][rg];
        4'h8: for (int p = 0; p < 4; p++) mD[p][rg] = mW[p];
        4'h2: for (int s = 0; s < steps; s++) begin
          logic up;
          up = $urandom % 2;
          doStep(up);
          if (up && mW[pot] != 6'h3F) mW[pot] = mW[pot] + 1;
          else if (!up && mW[pot] != 0) mW[pot] = mW[pot] - 1;
        end
        default: begin
          sendByte(8'h00, ack); check("R12 post two-byte nack", ack, 0);
        end
      endcase
    end
    doStop();
    if (op == 4'h9 || op == 4'hB) check("R5 txValid cleared by stop", txValid, 0);
    idle(1);
    checkWipers("R3 R6 R8 R10 R11 wiper");
    if (isKnown(op) && isNv(op) && !(abort && op == 4'hC)) idle(NV);
    if (isKnown(op) && op == 4'hC && !abort) idle(NV);
  endtask

  task automatic readDr(logic [1:0] pot, logic [1:0] rg, string req);
    logic ack;
    doStart();
    sendByte(ADDR, ack);
    sendByte({4'hB, pot, rg}, ack);
    check(req, txByte, {2'b00, mD[pot][rg]});
    doStop();
  endtask

  initial begin : main
    logic ack;
    void'($urandom(32'd1234));
    for (int p = 0; p < 4; p++) begin
      mW[p] = '0;
      for (int r = 0; r < 4; r++) mD[p][r] = '0;
    end
    idle(3);
    rstN = 1;
    @(negedge clk);
    check("R13 reset ackEn", ackEn, 0);
    check("R13 reset txValid", txValid, 0);
    check("R13 reset txByte", txByte, 0);
    check("R13 reset wipers", wiperBus, 0);

    // R1 wrong address
    doStart();
    sendByte({4'b0101, 4'h3}, ack); check("R1 wrong address nack", ack, 0);
    sendByte({4'hA, 4'h0}, ack); check("R1 ignored after nack", ack, 0);
    doStop();

    // R3 write WCR, wiper one clock after
    doStart(); sendByte(ADDR, ack); sendByte({4'hA, 2'd2, 2'd0}, ack);
    sendByte(8'hD5, ack);   // WCR changes at this edge
    check("R3 wiper not yet", wiperBus[12 +: 6], 0);
    @(negedge clk);
    check("R3 wiper follows", wiperBus[12 +: 6], 6'h15);
    mW[2] = 6'h15;
    doStop();

    // R10 abort write WCR and write DR
    runOp(4'hA, 2'd1, 2'd0, 6'h2A, 0, 1);
    runOp(4'hC, 2'd1, 2'd3, 6'h2A, 0, 1);
    readDr(2'd1, 2'd3, "R10 aborted DR unchanged");

    // R2 undefined opcodes
    for (int k = 0; k < 16; k++)
      if (!isKnown(4'(k))) runOp(4'(k), 2'd2, 2'd1, 6'h11, 0, 0);

    // R9 boundary: address one clock before the window ends
    runOp(4'hA, 2'd3, 2'd0, 6'h07, 0, 0);
    doStart(); sendByte(ADDR, ack); sendByte({4'hC, 2'd3, 2'd2}, ack);
    sendByte(8'h0B, ack); mD[3][2] = 6'h0B;
    doStop(); doStart(); idle(NV - 3);
    sendByte(ADDR, ack); check("R9 address in last busy clock nack", ack, 0);
    doStop();
    // R9 boundary: address right after the window ends
    doStart(); sendByte(ADDR, ack); sendByte({4'hE, 2'd3, 2'd1}, ack);
    mD[3][1] = mW[3];
    doStop(); doStart(); idle(NV - 2);
    sendByte(ADDR, ack); check("R9 address after window ack", ack, 1);
    doStop();
    readDr(2'd3, 2'd2, "R4 stored DR");
    readDr(2'd3, 2'd1, "R7 WCR to DR");

    // R11 saturation
    runOp(4'hA, 2'd0, 2'd0, 6'h3E, 0, 0);
    doStart(); sendByte(ADDR, ack); sendByte({4'h2, 2'd0, 2'd0}, ack);
    check("R11 step opcode ack", ack, 1);
    for (int s = 0; s < 3; s++) doStep(1);
    idle(1); check("R11 ceiling 63", wiperBus[5:0], 63);
    for (int s = 0; s < 66; s++) doStep(0);
    idle(1); check("R11 floor 0", wiperBus[5:0], 0);
    mW[0] = 0;
    doStop();

    // R8 global transfers
    for (int p = 0; p < 4; p++) runOp(4'hA, 2'(p), 2'd0, 6'(p * 9 + 5), 0, 0);
    runOp(4'h8, 2'd1, 2'd2, 6'h0, 0, 0);
    for (int p = 0; p < 4; p++) readDr(2'(p), 2'd2, "R8 global store");
    for (int p = 0; p < 4; p++) runOp(4'hA, 2'(p), 2'd0, 6'h01, 0, 0);
    runOp(4'h1, 2'd0, 2'd2, 6'h0, 0, 0);
    runOp(4'hD, 2'd1, 2'd3, 6'h0, 0, 0);  // R6 single load

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      logic [3:0] op;
      int sel;
      sel = $urandom % 10;
      case (sel)
        0: op = 4'h9; 1: op = 4'hA; 2: op = 4'hB; 3: op = 4'hC; 4: op = 4'hD;
        5: op = 4'hE; 6: op = 4'h1; 7: op = 4'h8; 8: op = 4'h2;
        default: op = 4'($urandom % 16);
      endcase
      runOp(op, 2'($urandom % 4), 2'($urandom % 4), 6'($urandom % 64),
            int'($urandom % 8), ($urandom % 8) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule